// File: doc/BRIEF.md
# Parallel-bus SPI master with software-driven I2C lines

This block hangs off an 8-bit parallel peripheral bus that has a small address field, an active-low write strobe and an active-low select. It answers at two consecutive addresses. The lower address is a byte-wide shift register: the CPU loads it with the byte to send and later reads back the byte received. The upper address is a control byte. Writing it sets four active-low SPI device selects and two open-drain I2C lines. Reading it returns those selects together with the pin levels on the I2C lines, and it also starts an 8-bit SPI exchange.

The exchange runs in SPI mode 0 with the most significant bit first. The serial clock is derived from the system clock by a parameterised half-period count. During the exchange the bits received on MISO replace the register contents bit by bit. While an exchange is running, any further start request is ignored. Software sequences the I2C protocol itself by writing and reading the control byte.

All bus inputs are sampled on the system clock. A write takes effect on the clock after select is seen to go high, and it uses the address, strobe and data from the last cycle in which select was low. Read data is taken from live state in the first cycle of select and is then held until select is released.

Top module: `busspi_port`

## Requirements
- R1: After reset all four selects are high, neither I2C line is pulled low, SCK is low, the bus is not driven and the data register reads 0x00.
- R2: A write to address BASE_ADDR loads the data register, and a later read of that address returns the written byte.
- R3: A write to address BASE_ADDR+1 copies bit 3..0 to spi_cs_n[3:0], and any number of those bits may be low at once. It sets SCL from bit 4 and SDA from bit 5, where a 0 pulls the line low and a 1 releases it.
- R4: A read of address BASE_ADDR+1 returns spi_cs_n in bits 3..0, zeros in bits 5..4, the sampled SCL pin level in bit 6 and the sampled SDA pin level in bit 7.
- R5: A read of BASE_ADDR+1 while idle starts an exchange in the clock that sees select open. SCK idles low and toggles every DIV_HALF clocks, giving exactly 8 rising edges, after which SCK rests low.
- R6: MISO is sampled at each SCK rising edge. After the exchange, the data register holds the 8 sampled bits with the first bit in bit 7.
- R7: A control-port read during an exchange neither restarts nor extends it. It still returns the control byte.
- R8: A write to the data register during an exchange is ignored.
- R9: bus_doe is high only while select is low, the write strobe is high and the address is one of the two ports. The value on bus_dout stays fixed for the whole select, even if its source changes.
- R10: Writes and reads at any other address have no effect on the block's state and do not drive the bus.
- R11: MOSI presents the data register's bit 7 before the first SCK rise and changes only while SCK is low, so the byte goes out MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_sel_n | input | 1 | Active-low bus select |
| bus_din | input | 8 | Write data from the CPU |
| bus_dout | output | 8 | Read data to the CPU |
| bus_doe | output | 1 | High when bus_dout should drive the bus |
| spi_sck | output | 1 | SPI serial clock |
| spi_mosi | output | 1 | SPI data out |
| spi_miso | input | 1 | SPI data in |
| spi_cs_n | output | 4 | Active-low device selects |
| scl_pull_low | output | 1 | Pulls SCL low when high |
| scl_pin | input | 1 | Synchronised SCL pin level |
| sda_pull_low | output | 1 | Pulls SDA low when high |
| sda_pin | input | 1 | Synchronised SDA pin level |

## Verification
The assertions take for granted that the bus inputs are already synchronous to clk. They also assume that select is held high throughout reset, that each select lasts at least two clocks, and that address and write strobe stay steady while select is low. The bench changes every bus input only on the falling clock edge and keeps the address and strobe fixed for each select of two clocks. The SPI slave in the bench changes MISO only on SCK falling edges, so the sampled level is never ambiguous.

// File: rtl/busspi_pkg.sv
// Shared constants and types for the bus SPI port.
// Assumes an 8-bit bus and exactly four device selects; bit positions
// in the control byte are fixed because software decodes them.
package busspi_pkg;
    localparam int DATA_W     = 8;
    localparam int NUM_CS     = 4;
    localparam int SCL_WR_BIT = 4;
    localparam int SDA_WR_BIT = 5;
    localparam int SCL_RD_BIT = 6;
    localparam int SDA_RD_BIT = 7;

    typedef enum logic [1:0] {
        PORT_NONE = 2'd0,
        PORT_DATA = 2'd1,
        PORT_CTRL = 2'd2
    } port_sel_t;
endpackage

// File: rtl/busspi_bus_if.sv
// Bus front end: samples the parallel bus on clk, decodes the two ports,
// produces write strobes at the close of select and a control-read strobe
// at its opening, and drives read data held for the whole select.
// Assumes bus inputs are synchronous to clk and select lasts >= 2 clocks.
module busspi_bus_if import busspi_pkg::*; #(
    parameter int ADDR_W    = 4,
    parameter int BASE_ADDR = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_n,
    input  logic              bus_sel_n,
    input  logic [DATA_W-1:0] bus_din,
    input  logic [DATA_W-1:0] data_rd_val,
    input  logic [DATA_W-1:0] ctrl_rd_val,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    output logic              data_wr_stb,
    output logic              ctrl_wr_stb,
    output logic              ctrl_rd_stb,
    output logic [DATA_W-1:0] wr_val
);
    localparam logic [ADDR_W-1:0] DATA_PORT = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] CTRL_PORT = ADDR_W'(BASE_ADDR + 1);

    logic              sel_q;
    logic              wr_n_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] din_q;
    logic [DATA_W-1:0] hold_q;
    logic              sel_open;
    logic              sel_close;
    logic              rd_hit;
    port_sel_t         live_port;
    port_sel_t         past_port;
    logic [DATA_W-1:0] live_val;

    function automatic port_sel_t decode(input logic [ADDR_W-1:0] a);
        if (a == DATA_PORT) return PORT_DATA;
        if (a == CTRL_PORT) return PORT_CTRL;
        return PORT_NONE;
    endfunction

    // Decode the present and previous-cycle address and pick the read source.
    always_comb begin
        live_port = decode(bus_addr);
        past_port = decode(addr_q);
        live_val  = (live_port == PORT_CTRL) ? ctrl_rd_val : data_rd_val;
        sel_open  = !bus_sel_n && sel_q;
        sel_close = bus_sel_n && !sel_q;
        rd_hit    = !bus_sel_n && bus_wr_n && (live_port != PORT_NONE);
    end

    // Remember last cycle's bus inputs and capture read data at select opening.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b1;
            wr_n_q <= 1'b1;
            addr_q <= '0;
            din_q  <= '0;
            hold_q <= '0;
        end else begin
            sel_q  <= bus_sel_n;
            wr_n_q <= bus_wr_n;
            addr_q <= bus_addr;
            din_q  <= bus_din;
            if (sel_open) hold_q <= live_val;
        end
    end

    // Form strobes and the read path.
    always_comb begin
        data_wr_stb = sel_close && !wr_n_q && (past_port == PORT_DATA);
        ctrl_wr_stb = sel_close && !wr_n_q && (past_port == PORT_CTRL);
        ctrl_rd_stb = sel_open && bus_wr_n && (live_port == PORT_CTRL);
        wr_val      = din_q;
        bus_doe     = rd_hit;
        bus_dout    = rd_hit ? (sel_open ? live_val : hold_q) : '0;
    end

    // R9
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_doe && $past(bus_doe) && $stable(bus_addr)) |-> $stable(bus_dout));

    // R7
    trig_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd_stb |=> !ctrl_rd_stb);
endmodule

// File: rtl/busspi_ctrl_reg.sv
// Control register: holds the device selects and the two open-drain line
// states, and assembles the control read-back byte from the live pins.
// Assumes scl_pin and sda_pin are already synchronised to clk.
module busspi_ctrl_reg import busspi_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [5:0]        wr_val,
    input  logic              scl_pin,
    input  logic              sda_pin,
    output logic [NUM_CS-1:0] cs_n,
    output logic              scl_pull_low,
    output logic              sda_pull_low,
    output logic [DATA_W-1:0] rd_val
);
    logic [NUM_CS-1:0] cs_q;
    logic              scl_q;
    logic              sda_q;

    // Load selects and line states on a control write; release all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q  <= '1;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else if (wr_stb) begin
            cs_q  <= wr_val[NUM_CS-1:0];
            scl_q <= wr_val[SCL_WR_BIT];
            sda_q <= wr_val[SDA_WR_BIT];
        end
    end

    // Open-drain drive and read-back assembly.
    always_comb begin
        cs_n                = cs_q;
        scl_pull_low        = !scl_q;
        sda_pull_low        = !sda_q;
        rd_val              = '0;
        rd_val[NUM_CS-1:0]  = cs_q;
        rd_val[SCL_RD_BIT]  = scl_pin;
        rd_val[SDA_RD_BIT]  = sda_pin;
    end

    // R3
    cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_stb) |-> ($stable(cs_n) && $stable(scl_pull_low) && $stable(sda_pull_low)));
endmodule

// File: rtl/busspi_shift.sv
// SPI mode-0 shift engine: on start, clocks out 8 bits MSB first with SCK
// toggling every DIV_HALF clocks, samples MISO on each SCK rise and shifts
// it in on the following fall. Loads and starts are ignored while busy.
module busspi_shift import busspi_pkg::*; #(
    parameter int DIV_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic [DATA_W-1:0] shreg
);
    localparam int CNT_W   = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam int BIT_W   = $clog2(DATA_W);
    localparam int RUN_CYC = 2 * DATA_W * DIV_HALF;
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(DIV_HALF - 1);
    localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(DATA_W - 1);

    logic              busy;
    logic [CNT_W-1:0]  half_cnt;
    logic [BIT_W-1:0]  bit_cnt;
    logic              rx_bit;
    logic [DATA_W-1:0] sr;
    logic [31:0]       run_len;

    // Sequence one transfer: divide, toggle SCK, sample on rise, shift on fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            half_cnt <= '0;
            bit_cnt  <= '0;
            sck      <= 1'b0;
            rx_bit   <= 1'b0;
            sr       <= '0;
        end else if (!busy) begin
            if (start) begin
                busy     <= 1'b1;
                half_cnt <= '0;
                bit_cnt  <= '0;
                sck      <= 1'b0;
            end else if (load) begin
                sr <= load_val;
            end
        end else if (half_cnt == HALF_LAST) begin
            half_cnt <= '0;
            sck      <= !sck;
            if (!sck) begin
                rx_bit <= miso;
            end else begin
                sr      <= {sr[DATA_W-2:0], rx_bit};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == BIT_LAST) busy <= 1'b0;
            end
        end else begin
            half_cnt <= half_cnt + 1'b1;
        end
    end

    // Checker-only length counter for the busy window.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) run_len <= '0;
        else                 run_len <= run_len + 1'b1;
    end

    assign mosi  = sr[DATA_W-1];
    assign shreg = sr;

    // R5
    idle_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

    // R5
    run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == 32'(RUN_CYC)));

    // R11
    mosi_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));
endmodule

// File: rtl/busspi_port.sv
// Top of the bus SPI port: data register at BASE_ADDR, control byte at
// BASE_ADDR+1. A control read starts an exchange; a control write sets the
// device selects and the open-drain I2C lines.
// Assumes bus inputs and the I2C pin levels are synchronous to clk.
module busspi_port import busspi_pkg::*; #(
    parameter int ADDR_W    = 4,
    parameter int BASE_ADDR = 6,
    parameter int DIV_HALF  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_n,
    input  logic              bus_sel_n,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs_n,
    output logic              scl_pull_low,
    input  logic              scl_pin,
    output logic              sda_pull_low,
    input  logic              sda_pin
);
    logic              data_wr_stb;
    logic              ctrl_wr_stb;
    logic              ctrl_rd_stb;
    logic [DATA_W-1:0] wr_val;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] ctrl_rd_val;

    busspi_bus_if #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr_n    (bus_wr_n),
        .bus_sel_n   (bus_sel_n),
        .bus_din     (bus_din),
        .data_rd_val (shreg),
        .ctrl_rd_val (ctrl_rd_val),
        .bus_dout    (bus_dout),
        .bus_doe     (bus_doe),
        .data_wr_stb (data_wr_stb),
        .ctrl_wr_stb (ctrl_wr_stb),
        .ctrl_rd_stb (ctrl_rd_stb),
        .wr_val      (wr_val)
    );

    busspi_ctrl_reg u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_stb       (ctrl_wr_stb),
        .wr_val       (wr_val[5:0]),
        .scl_pin      (scl_pin),
        .sda_pin      (sda_pin),
        .cs_n         (spi_cs_n),
        .scl_pull_low (scl_pull_low),
        .sda_pull_low (sda_pull_low),
        .rd_val       (ctrl_rd_val)
    );

    busspi_shift #(
        .DIV_HALF (DIV_HALF)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (ctrl_rd_stb),
        .load     (data_wr_stb),
        .load_val (wr_val),
        .miso     (spi_miso),
        .sck      (spi_sck),
        .mosi     (spi_mosi),
        .shreg    (shreg)
    );
endmodule

// File: tb/busspi_port_tb.sv
module busspi_port_tb;
    localparam int CLK_P   = 10;
    localparam int DIV     = 2;
    localparam int SEL_CYC = 2;
    localparam int LIMIT   = 20000;
    localparam logic [3:0] DATA_A = 4'h6;
    localparam logic [3:0] CTRL_A = 4'h7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr_n = 1'b1;
    logic       bus_sel_n = 1'b1;
    logic [7:0] bus_din = '0;
    logic [7:0] bus_dout;
    logic       bus_doe;
    logic       spi_sck, spi_mosi, spi_miso;
    logic [3:0] spi_cs_n;
    logic       scl_pull_low, sda_pull_low;
    logic       scl_ext = 1'b1, sda_ext = 1'b1;
    logic       scl_pin, sda_pin;

    int total = 0;
    int bad = 0;
    bit cmp_on = 1'b0;

    assign scl_pin = !scl_pull_low && scl_ext;
    assign sda_pin = !sda_pull_low && sda_ext;

    always #(CLK_P/2) clk = !clk;

    busspi_port #(.ADDR_W(4), .BASE_ADDR(6), .DIV_HALF(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_n(bus_wr_n),
        .bus_sel_n(bus_sel_n), .bus_din(bus_din), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .scl_pull_low(scl_pull_low),
        .scl_pin(scl_pin), .sda_pull_low(sda_pull_low), .sda_pin(sda_pin)
    );

    // SPI slave: shifts out on SCK fall, captures MOSI on SCK rise
    logic [7:0] slave_sr = '0;
    logic [7:0] slave_rx = '0;
    int rise_cnt = 0;
    assign spi_miso = slave_sr[7];
    always @(negedge spi_sck) slave_sr <= slave_sr << 1;
    always @(posedge spi_sck) begin
        slave_rx <= {slave_rx[6:0], spi_mosi};
        rise_cnt <= rise_cnt + 1;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising clock
    logic [7:0] m_sr, m_hold;
    logic [3:0] m_cs;
    logic       m_scl, m_sda, m_busy, m_sck, m_mbit;
    int         m_half, m_bits;
    logic       p_sel, p_wr;
    logic [3:0] p_addr;
    logic [7:0] p_din;
    logic       opening, closing;

    function automatic logic [7:0] live_read(input logic [3:0] a);
        if (a == CTRL_A) return {m_sda & sda_ext, m_scl & scl_ext, 2'b00, m_cs};
        return m_sr;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sr = '0; m_hold = '0; m_cs = 4'hF; m_scl = 1; m_sda = 1;
            m_busy = 0; m_sck = 0; m_mbit = 0; m_half = 0; m_bits = 0;
            p_sel = 1; p_wr = 1; p_addr = '0; p_din = '0;
        end else begin
            opening = !bus_sel_n && p_sel;
            closing = bus_sel_n && !p_sel;
            if (opening) m_hold = live_read(bus_addr);
            if (!m_busy) begin
                if (opening && bus_wr_n && bus_addr == CTRL_A) begin
                    m_busy = 1; m_half = 0; m_sck = 0; m_bits = 0;
                end else if (closing && !p_wr && p_addr == DATA_A) begin
                    m_sr = p_din;
                end
            end else if (m_half == DIV - 1) begin
                m_half = 0;
                if (!m_sck) begin
                    m_mbit = spi_miso; m_sck = 1;
                end else begin
                    m_sr = {m_sr[6:0], m_mbit}; m_sck = 0; m_bits++;
                    if (m_bits == 8) m_busy = 0;
                end
            end else begin
                m_half++;
            end
            if (closing && !p_wr && p_addr == CTRL_A) begin
                m_cs = p_din[3:0]; m_scl = p_din[4]; m_sda = p_din[5];
            end
            p_sel = bus_sel_n; p_wr = bus_wr_n; p_addr = bus_addr; p_din = bus_din;
        end
    end

    // Per-cycle comparison, a quarter period after the falling edge
    always @(negedge clk) begin
        #(CLK_P/4);
        if (cmp_on) begin
            logic exp_doe;
            check(spi_sck === m_sck, "R5 sck", spi_sck, m_sck);
            check(spi_mosi === m_sr[7], "R11 mosi", spi_mosi, m_sr[7]);
            check(spi_cs_n === m_cs, "R3 cs_n", spi_cs_n, m_cs);
            check(scl_pull_low === !m_scl, "R3 scl drive", scl_pull_low, !m_scl);
            check(sda_pull_low === !m_sda, "R3 sda drive", sda_pull_low, !m_sda);
            exp_doe = !bus_sel_n && bus_wr_n && (bus_addr == DATA_A || bus_addr == CTRL_A);
            check(bus_doe === exp_doe, "R9/R10 doe", bus_doe, exp_doe);
            if (exp_doe)
                check(bus_dout === (p_sel ? live_read(bus_addr) : m_hold), "R9 dout",
                      bus_dout, p_sel ? live_read(bus_addr) : m_hold);
        end
    end

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr_n = 0; bus_din = d; bus_sel_n = 0;
        repeat (SEL_CYC) @(negedge clk);
        bus_sel_n = 1;
        @(negedge clk);
        bus_wr_n = 1; bus_din = '0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] v, output logic oe);
        @(negedge clk);
        bus_addr = a; bus_wr_n = 1; bus_sel_n = 0;
        #(CLK_P/4);
        v = bus_dout; oe = bus_doe;
        repeat (SEL_CYC - 1) @(negedge clk);
        #(CLK_P/4);
        if (oe) check(bus_dout === v, "R9 held read", bus_dout, v);
        @(negedge clk);
        bus_sel_n = 1;
    endtask

    task automatic wait_done();
        repeat (16 * DIV + 6) @(negedge clk);
    endtask

    initial begin
        repeat (LIMIT) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic oe;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;
        #(CLK_P/4);
        // R1 reset state
        check(spi_cs_n === 4'hF, "R1 cs_n", spi_cs_n, 4'hF);
        check(!scl_pull_low && !sda_pull_low, "R1 i2c released", {scl_pull_low, sda_pull_low}, 0);
        check(spi_sck === 1'b0, "R1 sck", spi_sck, 0);
        check(bus_doe === 1'b0, "R1 doe", bus_doe, 0);
        bus_read(DATA_A, v, oe);
        check(v === 8'h00, "R1 data reg", v, 8'h00);

        // R2 data register write/read
        bus_write(DATA_A, 8'h5A);
        bus_read(DATA_A, v, oe);
        check(v === 8'h5A, "R2 readback", v, 8'h5A);
        bus_write(DATA_A, 8'hA5);
        bus_read(DATA_A, v, oe);
        check(v === 8'hA5 && oe, "R2 readback", v, 8'hA5);

        // R3 control write
        bus_write(CTRL_A, 8'h3A);
        #(CLK_P/4);
        check(spi_cs_n === 4'hA, "R3 cs_n", spi_cs_n, 4'hA);

        // R4/R5/R6/R11 first exchange
        slave_sr = 8'h3C; rise_cnt = 0;
        bus_read(CTRL_A, v, oe);
        check(v === 8'hCA, "R4 ctrl read", v, 8'hCA);
        wait_done();
        check(rise_cnt == 8, "R5 sck rises", rise_cnt, 8);
        check(slave_rx === 8'hA5, "R11 mosi byte", slave_rx, 8'hA5);
        bus_read(DATA_A, v, oe);
        check(v === 8'h3C, "R6 rx byte", v, 8'h3C);

        // R3 all selects low, both lines pulled; R4 reads pulled pins
        bus_write(CTRL_A, 8'h00);
        #(CLK_P/4);
        check(spi_cs_n === 4'h0, "R3 multi cs low", spi_cs_n, 4'h0);
        check(scl_pull_low && sda_pull_low, "R3 i2c pulled", {scl_pull_low, sda_pull_low}, 2'b11);
        slave_sr = 8'h81; rise_cnt = 0;
        bus_read(CTRL_A, v, oe);
        check(v === 8'h00, "R4 ctrl read pulled", v, 8'h00);
        wait_done();
        bus_read(DATA_A, v, oe);
        check(v === 8'h81, "R6 rx byte", v, 8'h81);
        check(slave_rx === 8'h3C, "R11 mosi byte", slave_rx, 8'h3C);

        // R4 external device holds SDA low while released
        bus_write(CTRL_A, 8'h25);
        sda_ext = 1'b0;
        slave_sr = 8'hE7; rise_cnt = 0;
        bus_read(CTRL_A, v, oe);
        check(v === 8'h05, "R4 sda pin level", v, 8'h05);
        sda_ext = 1'b1;
        // R8 write during exchange; R7 control read during exchange
        bus_write(DATA_A, 8'hFF);
        bus_read(CTRL_A, v, oe);
        check(v === 8'h85, "R7 ctrl read busy", v, 8'h85);
        wait_done();
        check(rise_cnt == 8, "R7 no restart", rise_cnt, 8);
        bus_read(DATA_A, v, oe);
        check(v === 8'hE7, "R8 write ignored", v, 8'hE7);
        check(slave_rx === 8'h81, "R11 mosi byte", slave_rx, 8'h81);

        // R10 foreign addresses
        bus_write(4'h3, 8'h12);
        bus_write(4'hF, 8'h34);
        bus_read(4'h3, v, oe);
        check(oe === 1'b0, "R10 no drive", oe, 0);
        bus_read(4'h0, v, oe);
        check(oe === 1'b0, "R10 no drive", oe, 0);
        bus_read(DATA_A, v, oe);
        check(v === 8'hE7, "R10 data kept", v, 8'hE7);
        check(spi_cs_n === 4'h5, "R10 cs kept", spi_cs_n, 4'h5);

        // R9 read value held while its source changes mid-select
        @(negedge clk);
        bus_addr = CTRL_A; bus_wr_n = 1; bus_sel_n = 0;
        #(CLK_P/4);
        v = bus_dout;
        check(v === 8'h85, "R9 open value", v, 8'h85);
        @(negedge clk);
        sda_ext = 1'b0;
        #(CLK_P/4);
        check(bus_dout === 8'h85 && bus_doe, "R9 held value", bus_dout, 8'h85);
        @(negedge clk);
        bus_sel_n = 1;
        #(CLK_P/4);
        check(bus_doe === 1'b0, "R9 released", bus_doe, 0);
        sda_ext = 1'b1;
        wait_done();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule